// File: doc/BRIEF.md
# SDRAM Self-Refresh Entry and Exit Sequencer

This block takes the SDRAM command pins away from the normal controller when a power manager asks for self-refresh, and gives them back afterwards. The power manager raises a request. The sequencer waits until the controller reports that every bank is idle. It then issues a burst of auto-refresh commands, issues the self-refresh command, and holds the clock enable low.

When the request drops, the sequencer raises the clock enable and keeps the bus quiet for the exit delay. It then runs a second auto-refresh burst and releases the bus. The acknowledge output follows a four-phase handshake. It rises once the device sits in self-refresh. It falls only after the exit burst has finished. The burst length and both delays are parameters, so tests can shorten them.

An ownership output tells the surrounding controller when the sequencer drives the command pins. While the sequencer waits for the banks to close, it does not own the bus. The controller still needs the bus during that time to precharge open banks.

Top module: `sdram_sref_sequencer`

## Requirements
- R1: During and after reset, with no request, the pins read cs_n=0, ras_n=1, cas_n=1, we_n=1, cke=1 (NOP), and sr_ack=0 and seq_owns=0.
- R2: While a request is pending and banks_idle is low, the block issues no refresh and leaves seq_owns low. It keeps driving NOP.
- R3: If the request is withdrawn before banks_idle is seen high, the block returns to idle. It issues no command and never raises sr_ack.
- R4: The cycle after banks_idle is sampled high with a pending request, the first of exactly REF_COUNT auto-refresh commands appears. Auto-refresh is cs_n=0, ras_n=0, cas_n=0, we_n=1, cke=1. Refresh commands start T_RC cycles apart, with NOP in every cycle between them.
- R5: The self-refresh command (cs_n=0, ras_n=0, cas_n=0, we_n=1, cke=0) appears T_RC cycles after the last entry refresh.
- R6: From the self-refresh command onward, cke stays low as long as the request stays high. sr_ack is high from the cycle after the self-refresh command. The pins show NOP with cke low.
- R7: When the request is seen low in self-refresh, cke rises in the next cycle. Exactly T_XSR NOP cycles with cke high pass before the first exit refresh.
- R8: The exit burst has REF_COUNT refreshes at T_RC spacing with sr_ack held high. T_RC cycles after the last exit refresh, sr_ack and seq_owns both fall.
- R9: While seq_owns is low the pins show NOP with cke high. While seq_owns is high only NOP, auto-refresh or self-refresh appear. Once the bus is owned, banks_idle has no further effect.
- R10: If the request drops after the entry burst has started, entry still completes. The block then spends exactly one cycle in self-refresh (with sr_ack high) before the exit sequence begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sr_req | input | 1 | Self-refresh request from the power manager |
| banks_idle | input | 1 | High when every bank is precharged |
| sr_ack | output | 1 | Self-refresh acknowledge |
| seq_owns | output | 1 | High while the sequencer drives the command pins |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable |

## Verification
The bench walks complete handshakes cycle by cycle. It varies the bank-idle delay and the time spent in self-refresh, and it toggles banks_idle after the bus has been taken.

Several corner cases are targeted:
- A request withdrawn while the banks are still busy. A design that took the bus too early would emit refreshes here.
- A request dropped during the entry burst. A design that aborted would leave the device outside self-refresh with a half burst, or would hang with the acknowledge low.
- The exact NOP count after cke rises and the exact refresh spacing. Off-by-one timers show up as a command one cycle early or late.
- The instant the acknowledge falls. A premature release would hand the bus back while the exit burst is still running.

// File: rtl/sref_pkg.sv
// Shared types for the self-refresh sequencer.
// Holds the command kinds, the pin bundle they map onto, and the state encoding.
package sref_pkg;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_AREF = 2'd1,
        CMD_SREF = 2'd2
    } sdram_cmd_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    typedef enum logic [3:0] {
        ST_IDLE    = 4'd0,
        ST_WAIT    = 4'd1,
        ST_REF_IN  = 4'd2,
        ST_GAP_IN  = 4'd3,
        ST_SR_CMD  = 4'd4,
        ST_SELF    = 4'd5,
        ST_XSR     = 4'd6,
        ST_REF_OUT = 4'd7,
        ST_GAP_OUT = 4'd8
    } seq_state_e;

endpackage

// File: rtl/sref_cmd_encode.sv
// Maps a command kind onto the four active-low strobe pins.
// Assumes clock enable is handled separately by the caller.
module sref_cmd_encode
    import sref_pkg::*;
(
    input  sdram_cmd_e cmd,
    output cmd_pins_t  pins
);

    // Purely combinational decode of the command kind.
    always_comb begin
        unique case (cmd)
            CMD_AREF: pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
            CMD_SREF: pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
            default:  pins = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
    end

endmodule

// File: rtl/sref_timer.sv
// Loadable down-counter that flags the last cycle of a wait.
// After a load of N (N >= 1), at_one is high in the N-th following cycle.
module sref_timer #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic             at_one
);

    logic [WIDTH-1:0] cnt_q;

    // Load on request, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign at_one = (cnt_q == WIDTH'(1));

endmodule

// File: rtl/sref_ref_counter.sv
// Counts the refresh commands issued in one burst.
// reached goes high once COUNT steps have been taken since the last clear.
module sref_ref_counter #(
    parameter int COUNT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic reached
);

    localparam int CW = $clog2(COUNT + 1);

    logic [CW-1:0] cnt_q;

    // Clear wins over step; step adds one refresh.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear)
            cnt_q <= '0;
        else if (step)
            cnt_q <= cnt_q + 1'b1;
    end

    assign reached = (cnt_q == CW'(COUNT));

endmodule

// File: rtl/sdram_sref_sequencer.sv
// Self-refresh entry/exit sequencer.
// Waits for idle banks, issues REF_COUNT refreshes, enters self-refresh, and
// on release waits T_XSR cycles before refreshing again and freeing the bus.
// Assumes T_RC >= 2 and T_XSR >= 1. Outputs decode from the state register only.
module sdram_sref_sequencer
    import sref_pkg::*;
#(
    parameter int REF_COUNT = 4096,
    parameter int T_RC      = 8,
    parameter int T_XSR     = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sr_req,
    input  logic banks_idle,
    output logic sr_ack,
    output logic seq_owns,
    output logic cs_n,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic cke
);

    localparam int TMAX = (T_RC > T_XSR) ? T_RC : T_XSR;
    localparam int TW   = $clog2(TMAX + 1);

    seq_state_e      st_q, st_d;
    logic            tmr_load;
    logic [TW-1:0]   tmr_val;
    logic            tmr_at_one;
    logic            ref_clr, ref_step, ref_done;
    sdram_cmd_e      cmd;
    cmd_pins_t       pins;

    sref_timer #(.WIDTH(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .at_one   (tmr_at_one)
    );

    sref_ref_counter #(.COUNT(REF_COUNT)) u_refcnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (ref_clr),
        .step    (ref_step),
        .reached (ref_done)
    );

    sref_cmd_encode u_enc (
        .cmd  (cmd),
        .pins (pins)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    // Next-state, timer and counter control.
    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        ref_clr  = 1'b0;
        ref_step = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (sr_req) st_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (!sr_req) begin
                    st_d = ST_IDLE;
                end else if (banks_idle) begin
                    st_d    = ST_REF_IN;
                    ref_clr = 1'b1;
                end
            end
            ST_REF_IN: begin
                ref_step = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = TW'(T_RC - 1);
                st_d     = ST_GAP_IN;
            end
            ST_GAP_IN: begin
                if (tmr_at_one) st_d = ref_done ? ST_SR_CMD : ST_REF_IN;
            end
            ST_SR_CMD: begin
                st_d = ST_SELF;
            end
            ST_SELF: begin
                if (!sr_req) begin
                    st_d     = ST_XSR;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(T_XSR);
                    ref_clr  = 1'b1;
                end
            end
            ST_XSR: begin
                if (tmr_at_one) st_d = ST_REF_OUT;
            end
            ST_REF_OUT: begin
                ref_step = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = TW'(T_RC - 1);
                st_d     = ST_GAP_OUT;
            end
            ST_GAP_OUT: begin
                if (tmr_at_one) st_d = ref_done ? ST_IDLE : ST_REF_OUT;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Command kind and status decoded from the current state.
    always_comb begin
        unique case (st_q)
            ST_REF_IN, ST_REF_OUT: cmd = CMD_AREF;
            ST_SR_CMD:             cmd = CMD_SREF;
            default:               cmd = CMD_NOP;
        endcase
        cke      = !(st_q == ST_SR_CMD || st_q == ST_SELF);
        seq_owns = !(st_q == ST_IDLE || st_q == ST_WAIT);
        sr_ack   = (st_q == ST_SELF) || (st_q == ST_XSR) ||
                   (st_q == ST_REF_OUT) || (st_q == ST_GAP_OUT);
    end

    assign cs_n  = pins.cs_n;
    assign ras_n = pins.ras_n;
    assign cas_n = pins.cas_n;
    assign we_n  = pins.we_n;

endmodule

// File: rtl/sdram_sref_sequencer_chk.sv
// Property checker for the self-refresh sequencer, bound to every instance.
// Observes only the ports; spacing windows are measured with local counters.
module sdram_sref_sequencer_chk #(
    parameter int T_RC  = 8,
    parameter int T_XSR = 12
) (
    input logic clk,
    input logic rst_n,
    input logic sr_req,
    input logic banks_idle,
    input logic sr_ack,
    input logic seq_owns,
    input logic cs_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic cke
);

    logic is_ref, is_sref, is_nop;
    int   since_ref, since_cke;
    logic ref_seen, after_self;

    assign is_ref  = !cs_n && !ras_n && !cas_n && we_n && cke;
    assign is_sref = !cs_n && !ras_n && !cas_n && we_n && !cke;
    assign is_nop  = !cs_n && ras_n && cas_n && we_n;

    // Track cycles since the last refresh and since cke was last low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_ref  <= 0;
            since_cke  <= 0;
            ref_seen   <= 1'b0;
            after_self <= 1'b0;
        end else begin
            since_ref  <= is_ref ? 1 : ((since_ref < 1000000) ? since_ref + 1 : since_ref);
            since_cke  <= !cke ? 0 : ((since_cke < 1000000) ? since_cke + 1 : since_cke);
            ref_seen   <= is_ref ? 1'b1 : ((!seq_owns || !cke) ? 1'b0 : ref_seen);
            after_self <= !cke ? 1'b1 : (is_ref ? 1'b0 : after_self);
        end
    end

    a_r2_no_take_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_owns && !banks_idle) |=> !seq_owns);

    a_r4_ref_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ref && ref_seen) |-> (since_ref == T_RC));

    a_r5_sref_after_burst: assert property (@(posedge clk) disable iff (!rst_n)
        is_sref |-> (ref_seen && since_ref == T_RC));

    a_r6_cke_held_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && sr_req) |=> !cke);

    a_r7_cke_rise_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && sr_ack && !sr_req) |=> cke);

    a_r7_exit_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ref && after_self) |-> (since_cke == T_XSR));

    a_r8_ack_within_owns: assert property (@(posedge clk) disable iff (!rst_n)
        sr_ack |-> seq_owns);

    a_r9_legal_cmds: assert property (@(posedge clk) disable iff (!rst_n)
        seq_owns |-> (is_ref || is_sref || is_nop));

    a_r9_quiet_when_released: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_owns |-> (is_nop && cke));

endmodule

bind sdram_sref_sequencer sdram_sref_sequencer_chk #(
    .T_RC  (T_RC),
    .T_XSR (T_XSR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sr_req     (sr_req),
    .banks_idle (banks_idle),
    .sr_ack     (sr_ack),
    .seq_owns   (seq_owns),
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .cke        (cke)
);

// File: tb/test_sdram_sref_sequencer.sv
`timescale 1ns/1ps
// Bench: walks full request/acknowledge episodes and checks every cycle.
module test_sdram_sref_sequencer;

    localparam int P_REFS = 4;
    localparam int P_TRC  = 3;
    localparam int P_TXSR = 5;

    localparam int K_NOP   = 0;
    localparam int K_REF   = 1;
    localparam int K_SREF  = 2;
    localparam int K_SLEEP = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sr_req = 1'b0;
    logic banks_idle = 1'b0;
    logic sr_ack, seq_owns, cs_n, ras_n, cas_n, we_n, cke;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    sdram_sref_sequencer #(
        .REF_COUNT (P_REFS),
        .T_RC      (P_TRC),
        .T_XSR     (P_TXSR)
    ) i_sdram_sref_sequencer (
        .clk        (clk),
        .rst_n      (rst_n),
        .sr_req     (sr_req),
        .banks_idle (banks_idle),
        .sr_ack     (sr_ack),
        .seq_owns   (seq_owns),
        .cs_n       (cs_n),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .we_n       (we_n),
        .cke        (cke)
    );

    always #4 clk = ~clk;

    // Expected {cs_n, ras_n, cas_n, we_n, cke} for each command kind.
    function automatic logic [4:0] exp_pins(int kind);
        case (kind)
            K_REF:   return 5'b0_001_1;
            K_SREF:  return 5'b0_001_0;
            K_SLEEP: return 5'b0_111_0;
            default: return 5'b0_111_1;
        endcase
    endfunction

    task automatic chk(string tag, int kind, logic eack, logic eown);
        logic [4:0] act;
        act = {cs_n, ras_n, cas_n, we_n, cke};
        n_cmp++;
        if (act !== exp_pins(kind) || sr_ack !== eack || seq_owns !== eown) begin
            n_bad++;
            $display("FAIL %s cyc=%0d pins/ack/own=%b/%b/%b expected %b/%b/%b",
                     tag, cyc, act, sr_ack, seq_owns, exp_pins(kind), eack, eown);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // One handshake; wait_cyc = bank-busy cycles, hold = extra self-refresh cycles.
    task automatic episode(int wait_cyc, int hold, bit early, bit withdraw, bit jitter);
        sr_req = 1'b1;
        banks_idle = 1'b0;
        step();
        chk("R2", K_NOP, 1'b0, 1'b0);
        for (int i = 0; i < wait_cyc; i++) begin
            step();
            chk("R2", K_NOP, 1'b0, 1'b0);
        end
        if (withdraw) begin
            sr_req = 1'b0;
            for (int i = 0; i < 4; i++) begin
                step();
                chk("R3", K_NOP, 1'b0, 1'b0);
            end
            return;
        end
        banks_idle = 1'b1;
        step();
        for (int r = 0; r < P_REFS; r++) begin
            chk("R4", K_REF, 1'b0, 1'b1);
            if (early && r == 0) sr_req = 1'b0;
            if (jitter) banks_idle = $urandom_range(0, 1) != 0; // R9: ignored once owned
            for (int g = 0; g < P_TRC - 1; g++) begin
                step();
                chk("R4", K_NOP, 1'b0, 1'b1);
            end
            step();
        end
        chk("R5", K_SREF, 1'b0, 1'b1);
        step();
        chk(early ? "R10" : "R6", K_SLEEP, 1'b1, 1'b1);
        for (int h = 0; h < hold; h++) begin
            step();
            chk("R6", K_SLEEP, 1'b1, 1'b1);
        end
        sr_req = 1'b0;
        step();
        for (int x = 0; x < P_TXSR; x++) begin
            chk(early ? "R10" : "R7", K_NOP, 1'b1, 1'b1);
            step();
        end
        for (int r = 0; r < P_REFS; r++) begin
            chk("R8", K_REF, 1'b1, 1'b1);
            for (int g = 0; g < P_TRC - 1; g++) begin
                step();
                chk("R8", K_NOP, 1'b1, 1'b1);
            end
            step();
        end
        chk("R8", K_NOP, 1'b0, 1'b0);
        banks_idle = 1'b0;
        step();
        chk("R9", K_NOP, 1'b0, 1'b0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired at cyc=%0d", cyc);
        summary();
        $finish;
    end

    // Main stimulus: reset, directed corners, then seeded random episodes.
    initial begin
        void'($urandom(32'd5813));
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) step();
        chk("R1", K_NOP, 1'b0, 1'b0);
        rst_n = 1'b1;
        step();
        chk("R1", K_NOP, 1'b0, 1'b0);
        step();
        chk("R1", K_NOP, 1'b0, 1'b0);

        episode(0, 3, 1'b0, 1'b0, 1'b0);
        episode(6, 0, 1'b0, 1'b0, 1'b0);
        episode(2, 0, 1'b0, 1'b1, 1'b0);
        episode(1, 0, 1'b1, 1'b0, 1'b1);
        episode(0, 0, 1'b0, 1'b1, 1'b0);

        for (int e = 0; e < 12; e++) begin
            bit early_drop;
            bit withdraw;
            early_drop = ($urandom_range(0, 3) == 0);
            withdraw   = !early_drop && ($urandom_range(0, 4) == 0);
            episode($urandom_range(0, 7),
                    early_drop ? 0 : $urandom_range(0, 10),
                    early_drop, withdraw, 1'b1);
            for (int q = 0; q < $urandom_range(0, 3); q++) begin
                step();
                chk("R9", K_NOP, 1'b0, 1'b0);
            end
        end

        summary();
        $finish;
    end

endmodule